// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block takes an asynchronous serial line and turns it back into data words. A programmable divider makes a sampling tick at sixteen times the bit rate. The line passes through a two-stage synchronizer. When the line falls from high to low, the receiver starts a 16-tick window at that edge, so each frame is timed from its own start bit. The start bit, each data bit, the optional parity bit and the stop bit are all sampled at the middle of their bit time.

The word length (seven or eight bits) and the parity mode (none, even or odd) are set at run time and must match the sender. Each finished word is shown on a data output together with a one-cycle strobe. Three sticky flags report parity errors, framing errors and overruns. A read-acknowledge input tells the block that the consumer has taken the last word. A clear input resets the flags.

Top module: `oversampled_serial_rx`

## Requirements
- R1: The sampling tick fires once every `div_val`+1 clock cycles. One bit time is 16 ticks.
- R2: The line passes through two flip-flops before use. A start is only recognised when the line is high at one tick and low at the next. A line that stays low after a frame does not start another frame until it has gone high again.
- R3: The start bit is sampled on the 8th tick after the falling edge. Each later bit is sampled 16 ticks after the one before, which puts every sample at mid-bit.
- R4: If the line is high again at the start-bit sample, the start is rejected as a glitch. No word is produced, and the receiver goes back to waiting for an edge.
- R5: Data arrives least significant bit first. `cfg_eight_bits`=1 selects 8 data bits and 0 selects 7. In 7-bit mode `rx_data[7]` is 0.
- R6: Each completed frame pulses `rx_strobe` high for one clock at the stop-bit sample. `rx_data` carries the word from that cycle until the next word completes.
- R7: `cfg_parity` encodes the parity mode: 2'b00 none, 2'b01 even, 2'b10 odd, 2'b11 none. With parity on, one parity bit follows the data bits. The expected parity bit is the XOR of the data bits for even parity, and its inverse for odd parity. A mismatch sets `err_parity`.
- R8: A stop bit sampled low sets `err_frame`. The word is still delivered with its strobe.
- R9: If a word completes while the previous word has not been acknowledged by `rd_ack`, `err_overrun` is set.
- R10: The error flags stay set until `err_clear` is high for a clock. If a new error occurs in the same cycle as a clear, the flag stays set.
- R11: After reset, `rx_data` is 0, `rx_strobe` is 0 and all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | DIV_W | Tick divider; the tick period is div_val+1 clocks |
| rx_line | input | 1 | Asynchronous serial input; idles high |
| cfg_eight_bits | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_parity | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| rd_ack | input | 1 | Consumer has taken the current word |
| err_clear | input | 1 | Clears all sticky error flags |
| rx_data | output | 8 | Last received word |
| rx_strobe | output | 1 | One-cycle pulse when a word completes |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun |

## Verification
The vector table sends words that distinguish the cases that matter:
- Alternating-bit patterns catch a reversed bit order.
- A word with its top bit set, sent in 7-bit mode, shows whether the eighth bit is dropped.
- The same kind of word under even, odd and code-11 parity separates the parity modes.
- Frames with a flipped parity bit, or a low stop bit, must raise exactly the matching flag.

Directed cases cover three more behaviours:
- A short low pulse that must not produce a word.
- A line held low for many bit times that must produce exactly one word.
- Two unacknowledged words that must raise the overrun flag, which stays set until it is cleared.

// File: rtl/osr_pkg.sv
package osr_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_t;

  localparam logic [1:0] PAR_NONE = 2'b00;
  localparam logic [1:0] PAR_EVEN = 2'b01;
  localparam logic [1:0] PAR_ODD  = 2'b10;

  // Right-justify the shifted-in bits: a 7-bit word sits in [7:1] after shifting.
  function automatic logic [7:0] align_word(input logic [7:0] shreg, input logic eight);
    align_word = eight ? shreg : {1'b0, shreg[7:1]};
  endfunction

  // Parity bit that the sender should have put on the line.
  function automatic logic parity_bit(input logic [7:0] word, input logic odd);
    parity_bit = (^word) ^ odd;
  endfunction

  function automatic logic parity_enabled(input logic [1:0] mode);
    parity_enabled = (mode == PAR_EVEN) || (mode == PAR_ODD);
  endfunction

endpackage

// File: rtl/osr_tick_gen.sv
module osr_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div_val) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R1: two ticks in a row only when the divider is zero
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (!tick || $past(div_val) == '0));

endmodule

// File: rtl/osr_sync.sv
module osr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/osr_frame_core.sv
module osr_frame_core
  import osr_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line,
  input  logic       cfg_eight_bits,
  input  logic [1:0] cfg_parity,
  input  logic       rd_ack,
  input  logic       err_clear,
  output logic [7:0] rx_data,
  output logic       rx_strobe,
  output logic       err_parity,
  output logic       err_frame,
  output logic       err_overrun
);

  localparam int PH_W = $clog2(OVS);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2 - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);

  rx_state_t       state;
  logic [PH_W-1:0] phase;
  logic [2:0]      bit_idx;
  logic [7:0]      shreg;
  logic            par_seen;
  logic            line_prev;
  logic            pending;

  // Named internal events
  logic       start_seen, mid_hit, full_hit, glitch_reject, last_bit, par_on;
  logic       word_done, parity_bad, stop_bad, overrun_hit;
  logic [7:0] word_now;

  assign par_on        = parity_enabled(cfg_parity);
  assign start_seen    = tick && (state == RX_IDLE) && line_prev && !line;
  assign mid_hit       = tick && (phase == PH_MID);
  assign full_hit      = tick && (phase == PH_LAST);
  assign glitch_reject = (state == RX_START) && mid_hit && line;
  assign last_bit      = (bit_idx == (cfg_eight_bits ? 3'd7 : 3'd6));
  assign word_done     = (state == RX_STOP) && full_hit;
  assign word_now      = align_word(shreg, cfg_eight_bits);
  assign parity_bad    = par_on && (par_seen != parity_bit(word_now, cfg_parity == PAR_ODD));
  assign stop_bad      = !line;
  assign overrun_hit   = word_done && pending && !rd_ack;

  // Edge history, updated at tick rate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    line_prev <= 1'b1;
    else if (tick) line_prev <= line;
  end

  // Frame sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= RX_IDLE;
      phase    <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_seen <= 1'b0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (start_seen) begin
            state <= RX_START;
            phase <= '0;
          end
        end
        RX_START: begin
          if (mid_hit) begin
            phase   <= '0;
            bit_idx <= '0;
            state   <= line ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            phase <= phase + 1'b1;
          end
        end
        RX_DATA: begin
          if (full_hit) begin
            phase <= '0;
            shreg <= {line, shreg[7:1]};
            if (last_bit) state <= par_on ? RX_PAR : RX_STOP;
            else          bit_idx <= bit_idx + 1'b1;
          end else if (tick) begin
            phase <= phase + 1'b1;
          end
        end
        RX_PAR: begin
          if (full_hit) begin
            phase    <= '0;
            par_seen <= line;
            state    <= RX_STOP;
          end else if (tick) begin
            phase <= phase + 1'b1;
          end
        end
        RX_STOP: begin
          if (full_hit) begin
            phase <= '0;
            state <= RX_IDLE;
          end else if (tick) begin
            phase <= phase + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  // Word delivery and sticky flags (a new error wins over a clear)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_strobe   <= 1'b0;
      pending     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      rx_strobe <= word_done;
      if (word_done) rx_data <= word_now;
      if (word_done)   pending <= 1'b1;
      else if (rd_ack) pending <= 1'b0;
      err_parity  <= (err_parity  && !err_clear) || (word_done && parity_bad);
      err_frame   <= (err_frame   && !err_clear) || (word_done && stop_bad);
      err_overrun <= (err_overrun && !err_clear) || overrun_hit;
    end
  end

  // R6: a strobe leaves the sequencer idle
  a_r6_strobe_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> state == RX_IDLE);
  // R4: a rejected start produces no word
  a_r4_glitch_idle: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_reject |=> (state == RX_IDLE && !rx_strobe));
  // R7: parity flag only rises with a word
  a_r7_parity_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity) |-> rx_strobe);
  // R8: framing flag only rises with a word
  a_r8_frame_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame) |-> rx_strobe);
  // R9: overrun only rises with a word
  a_r9_overrun_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> rx_strobe);
  // R10: a clear with no new word empties all flags
  a_r10_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_clear) && !rx_strobe) |-> (!err_parity && !err_frame && !err_overrun));

endmodule

// File: rtl/oversampled_serial_rx.sv
module oversampled_serial_rx #(
  parameter int DIV_W     = 16,
  parameter int OVS       = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             rx_line,
  input  logic             cfg_eight_bits,
  input  logic [1:0]       cfg_parity,
  input  logic             rd_ack,
  input  logic             err_clear,
  output logic [7:0]       rx_data,
  output logic             rx_strobe,
  output logic             err_parity,
  output logic             err_frame,
  output logic             err_overrun
);

  logic tick;
  logic line_sync;

  osr_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_val (div_val),
    .tick    (tick)
  );

  osr_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (rx_line),
    .dout  (line_sync)
  );

  osr_frame_core #(.OVS(OVS)) u_core (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick           (tick),
    .line           (line_sync),
    .cfg_eight_bits (cfg_eight_bits),
    .cfg_parity     (cfg_parity),
    .rd_ack         (rd_ack),
    .err_clear      (err_clear),
    .rx_data        (rx_data),
    .rx_strobe      (rx_strobe),
    .err_parity     (err_parity),
    .err_frame      (err_frame),
    .err_overrun    (err_overrun)
  );

endmodule

// File: tb/test_oversampled_serial_rx.sv
module test_oversampled_serial_rx;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 3;
  localparam int BIT_CLKS   = 16 * (DIV + 1);
  localparam int NVEC       = 9;

  // {data[7:0], eight, parity[1:0], flip_parity, stop_level}
  localparam logic [12:0] VEC [NVEC] = '{
    {8'hA5, 1'b1, 2'b00, 1'b0, 1'b1},
    {8'h67, 1'b1, 2'b01, 1'b0, 1'b1},
    {8'h3C, 1'b1, 2'b10, 1'b0, 1'b1},
    {8'hD5, 1'b0, 2'b00, 1'b0, 1'b1},
    {8'h7F, 1'b0, 2'b01, 1'b0, 1'b1},
    {8'hA0, 1'b1, 2'b10, 1'b1, 1'b1},
    {8'h12, 1'b1, 2'b00, 1'b0, 1'b0},
    {8'h0E, 1'b0, 2'b10, 1'b0, 1'b1},
    {8'hFF, 1'b1, 2'b11, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [15:0] div_val = 16'(DIV);
  logic       rx_line = 1'b1;
  logic       cfg_eight_bits = 1'b1;
  logic [1:0] cfg_parity = 2'b00;
  logic       rd_ack = 1'b0;
  logic       err_clear = 1'b0;
  logic [7:0] rx_data;
  logic       rx_strobe, err_parity, err_frame, err_overrun;

  int checks = 0;
  int fails = 0;
  int strobes = 0;
  logic [7:0] got_word = '0;
  bit done = 1'b0;

  oversampled_serial_rx i_oversampled_serial_rx (
    .clk (clk), .rst_n (rst_n), .div_val (div_val), .rx_line (rx_line),
    .cfg_eight_bits (cfg_eight_bits), .cfg_parity (cfg_parity),
    .rd_ack (rd_ack), .err_clear (err_clear), .rx_data (rx_data),
    .rx_strobe (rx_strobe), .err_parity (err_parity), .err_frame (err_frame),
    .err_overrun (err_overrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && rx_strobe) begin
      strobes  = strobes + 1;
      got_word = rx_data;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    rx_line = 1'b1;
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic eight, input logic [1:0] par,
                            input logic flip, input logic stop_lvl);
    logic [7:0] w;
    w = eight ? d : {1'b0, d[6:0]};
    cfg_eight_bits = eight;
    cfg_parity = par;
    hold_bit(1'b0);
    for (int i = 0; i < (eight ? 8 : 7); i++) hold_bit(d[i]);
    if (par == 2'b01 || par == 2'b10) hold_bit((^w) ^ (par == 2'b10) ^ flip);
    hold_bit(stop_lvl);
    idle_bits(2);
  endtask

  task automatic pulse_clear_ack();
    @(negedge clk);
    err_clear = 1'b1;
    rd_ack = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    rd_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    // R11: reset state
    check(rx_data == 8'h00 && !rx_strobe, "R11 data/strobe", rx_data, 0);
    check({err_parity, err_frame, err_overrun} == 3'b000, "R11 flags",
          {err_parity, err_frame, err_overrun}, 0);
    rst_n = 1'b1;
    idle_bits(2);

    // Table: R1 R3 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] d, expw;
      logic eight, flip, stopv;
      logic [1:0] par;
      {d, eight, par, flip, stopv} = VEC[k];
      expw = eight ? d : {1'b0, d[6:0]};
      pulse_clear_ack();
      base = strobes;
      send_frame(d, eight, par, flip, stopv);
      check(strobes == base + 1, "R6 one strobe", strobes - base, 1);
      check(got_word == expw && rx_data == expw, "R5 R3 R1 data", rx_data, expw);
      check(err_parity == ((par == 2'b01 || par == 2'b10) && flip), "R7 parity flag",
            err_parity, (par == 2'b01 || par == 2'b10) && flip);
      check(err_frame == !stopv, "R8 frame flag", err_frame, !stopv);
      check(!err_overrun, "R9 no overrun when acked", err_overrun, 0);
    end

    // R4: short low glitch gives no word, then a real frame still decodes
    pulse_clear_ack();
    base = strobes;
    rx_line = 1'b0;
    repeat (BIT_CLKS / 4) @(negedge clk);
    idle_bits(3);
    check(strobes == base, "R4 glitch rejected", strobes - base, 0);
    send_frame(8'h5A, 1'b1, 2'b00, 1'b0, 1'b1);
    check(rx_data == 8'h5A && strobes == base + 1, "R4 recovery", rx_data, 8'h5A);

    // R2: line held low for 30 bit times yields exactly one word
    pulse_clear_ack();
    base = strobes;
    cfg_eight_bits = 1'b1;
    cfg_parity = 2'b00;
    rx_line = 1'b0;
    repeat (30 * BIT_CLKS) @(negedge clk);
    check(strobes == base + 1, "R2 no retrigger while low", strobes - base, 1);
    check(err_frame && rx_data == 8'h00, "R2 R8 low-line word", {err_frame, rx_data}, 9'h100);
    idle_bits(3);
    check(strobes == base + 1, "R2 rising line no word", strobes - base, 1);

    // R10: sticky parity across a good frame, then cleared
    pulse_clear_ack();
    send_frame(8'h81, 1'b1, 2'b01, 1'b1, 1'b1);
    pulse_clear_ack();
    check(!err_parity, "R10 clear", err_parity, 0);
    send_frame(8'h81, 1'b1, 2'b01, 1'b1, 1'b1);
    @(negedge clk); rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0;
    send_frame(8'h42, 1'b1, 2'b01, 1'b0, 1'b1);
    check(err_parity && rx_data == 8'h42, "R10 sticky parity", err_parity, 1);

    // R9: two unacknowledged words raise overrun; clear; ack prevents it
    pulse_clear_ack();
    send_frame(8'h11, 1'b1, 2'b00, 1'b0, 1'b1);
    check(!err_overrun, "R9 first word", err_overrun, 0);
    send_frame(8'h22, 1'b1, 2'b00, 1'b0, 1'b1);
    check(err_overrun && rx_data == 8'h22, "R9 overrun", err_overrun, 1);
    idle_bits(1);
    check(err_overrun, "R10 overrun sticky", err_overrun, 1);
    pulse_clear_ack();
    check(!err_overrun, "R10 overrun cleared", err_overrun, 0);
    send_frame(8'h33, 1'b1, 2'b00, 1'b0, 1'b1);
    check(!err_overrun && rx_data == 8'h33, "R9 acked no overrun", err_overrun, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule